// File: doc/BRIEF.md
# Interrupting Byte Port Controller

This block is a small peripheral that a processor reaches through ordinary memory reads and writes. It holds one byte received from an external device and one byte to send to that device. It also has a status byte with two readiness flags and two interrupt enables, and a programmable interrupt vector. The four registers sit on even addresses, two bytes apart, inside an eight-byte window that starts at a parameterised base address. The block works out which register an access targets. Reading the received byte clears the input-ready flag, and writing the outgoing byte clears the output-ready flag.

When a readiness flag is set and its enable is on, the block raises an interrupt request. The processor acknowledges interrupts through a daisy chain. A block with a request pending claims the acknowledge: it places its vector on the read-data bus and does not pass the acknowledge on. A block with no request forwards the acknowledge to the next block in the chain. Once claimed, the request stays low until the flags that caused it have been serviced. On the device side there is a byte-with-strobe input, a one-cycle output strobe carrying the written byte, and a consumed signal that marks the output register free again.

Top module: `byte_port_ctrl`

## Requirements
- R1: After reset the status register reads 0x02 (output ready, input not ready, both enables off), the vector register reads 0x00, and the interrupt request is low.
- R2: A cycle with `dev_in_valid` high stores `dev_in_data` and sets status bit 0 on the next edge. A read of offset 0 returns the stored byte, and status bit 0 is clear from the next edge on.
- R3: A write to offset 2 clears status bit 1 at the next edge and, in the cycle after the write, drives `dev_out_valid` high for exactly one cycle with the written byte on `dev_out_data`. A `dev_out_done` pulse sets status bit 1 again.
- R4: In the status register, bit 2 enables the input-ready interrupt and bit 3 enables the output-ready interrupt. Both can be read and written. Writes to bits 0 and 1 have no effect on the flags.
- R5: `irq_o` is high exactly when (bit 0 and bit 2) or (bit 1 and bit 3) is set and the request has not already been acknowledged.
- R6: While `iack_in` is high and `irq_o` is high, `bus_rdata` carries the vector register and `iack_out` is low. From the next edge `irq_o` stays low while the flag that caused it remains set.
- R7: Once no enabled flag is pending, a request that was acknowledged re-arms. A later enabled flag raises `irq_o` again.
- R8: While `iack_in` is high and no request is pending, `iack_out` is high and `bus_rdata` is 0x00.
- R9: The vector register is written and read at offset 6.
- R10: Accesses outside the eight-byte window, or to odd addresses, change no register, and `bus_rdata` reads 0x00 whenever no access is decoded and no acknowledge is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Processor bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data or claimed vector, zero otherwise |
| irq_o | output | 1 | Interrupt request |
| iack_in | input | 1 | Acknowledge arriving from the previous chain stage |
| iack_out | output | 1 | Acknowledge forwarded to the next chain stage |
| dev_in_valid | input | 1 | Device presents a received byte |
| dev_in_data | input | DATA_W | Received byte |
| dev_out_valid | output | 1 | One-cycle strobe for an outgoing byte |
| dev_out_data | output | DATA_W | Outgoing byte |
| dev_out_done | input | 1 | Device has consumed the outgoing byte |

## Verification
The hardest state to reach is an acknowledged request whose flag is still set. Here `irq_o` has to stay low even though the enabled flag is pending, and it must come back only after the flag has been serviced and set again. The bench gets there with a fixed sequence: it programs a vector, enables only the input interrupt, feeds a byte from the device side, and claims the acknowledge. It then reads status to confirm the flag is still set while the request is low. Finally it drains the byte and feeds another, and checks that the request rises again.

// File: rtl/byte_port_pkg.sv
// Shared register selectors and status bit positions for the byte port.
package byte_port_pkg;
    typedef enum logic [1:0] {
        SEL_RX   = 2'd0,
        SEL_TX   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_VEC  = 2'd3
    } port_reg_e;

    localparam int STAT_RX_RDY = 0;
    localparam int STAT_TX_RDY = 1;
    localparam int STAT_RX_IE  = 2;
    localparam int STAT_TX_IE  = 3;
endpackage

// File: rtl/byte_port_decode.sv
// Address decoder. It matches the eight-byte window at BASE and selects a register.
// Assumes: BASE is aligned to 8, and odd byte addresses are never decoded.
module byte_port_decode
    import byte_port_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h8000
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output port_reg_e         which,
    output logic              rd_rx,
    output logic              wr_tx,
    output logic              wr_stat,
    output logic              wr_vec
);
    localparam int HI = ADDR_W - 1;

    // Window match and register select
    always_comb begin
        hit     = sel && (addr[HI:3] == BASE[HI:3]) && !addr[0];
        which   = port_reg_e'(addr[2:1]);
        rd_rx   = hit && !wr && (which == SEL_RX);
        wr_tx   = hit &&  wr && (which == SEL_TX);
        wr_stat = hit &&  wr && (which == SEL_STAT);
        wr_vec  = hit &&  wr && (which == SEL_VEC);
    end
endmodule

// File: rtl/byte_port_regs.sv
// Register storage: data bytes, readiness flags, enables, vector, output strobe.
// Assumes: a new device byte wins over a same-cycle processor read, and a
// processor write to the output register wins over a same-cycle consumed pulse.
module byte_port_regs
    import byte_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_rx,
    input  logic              wr_tx,
    input  logic              wr_stat,
    input  logic              wr_vec,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_out_done,
    output logic [DATA_W-1:0] rx_q,
    output logic [DATA_W-1:0] tx_q,
    output logic [DATA_W-1:0] vec_q,
    output logic              rx_rdy,
    output logic              tx_rdy,
    output logic              rx_ie,
    output logic              tx_ie,
    output logic              tx_strobe
);
    // Received byte and input-ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q   <= '0;
            rx_rdy <= 1'b0;
        end else if (dev_in_valid) begin
            rx_q   <= dev_in_data;
            rx_rdy <= 1'b1;
        end else if (rd_rx) begin
            rx_rdy <= 1'b0;
        end
    end

    // Outgoing byte, output-ready flag and one-cycle device strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            tx_rdy    <= 1'b1;
            tx_strobe <= 1'b0;
        end else begin
            tx_strobe <= wr_tx;
            if (wr_tx) begin
                tx_q   <= wdata;
                tx_rdy <= 1'b0;
            end else if (dev_out_done) begin
                tx_rdy <= 1'b1;
            end
        end
    end

    // Interrupt enables, writable through the status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie <= 1'b0;
            tx_ie <= 1'b0;
        end else if (wr_stat) begin
            rx_ie <= wdata[STAT_RX_IE];
            tx_ie <= wdata[STAT_TX_IE];
        end
    end

    // Programmable interrupt vector
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (wr_vec) vec_q <= wdata;
    end
endmodule

// File: rtl/byte_port_irq.sv
// Interrupt request and daisy-chain acknowledge stage.
// Assumes: iack_in is a level held for the acknowledge cycle. A claimed request
// stays masked until no enabled flag is pending.
module byte_port_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_rdy,
    input  logic tx_rdy,
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic iack_in,
    output logic irq,
    output logic claim,
    output logic iack_out
);
    logic pending;
    logic served_q;

    // Request, claim and pass-on decisions
    always_comb begin
        pending  = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);
        irq      = pending && !served_q;
        claim    = iack_in && irq;
        iack_out = iack_in && !irq;
    end

    // Remember an acknowledged request until its cause is gone
    always_ff @(posedge clk) begin
        if (!rst_n)        served_q <= 1'b0;
        else if (!pending) served_q <= 1'b0;
        else if (claim)    served_q <= 1'b1;
    end
endmodule

// File: rtl/byte_port_ctrl.sv
// Top of the interrupting byte port. It wires the decoder, the register store
// and the acknowledge stage, and muxes the read bus.
// Assumes: a claimed acknowledge takes priority over a register read on bus_rdata.
module byte_port_ctrl
    import byte_port_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              iack_in,
    output logic              iack_out,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_done
);
    logic              hit, rd_rx, wr_tx, wr_stat, wr_vec, claim;
    port_reg_e         which;
    logic [DATA_W-1:0] rx_q, tx_q, vec_q, stat_v;
    logic              rx_rdy, tx_rdy, rx_ie, tx_ie;

    byte_port_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .hit(hit), .which(which),
        .rd_rx(rd_rx), .wr_tx(wr_tx), .wr_stat(wr_stat), .wr_vec(wr_vec)
    );

    byte_port_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_rx(rd_rx), .wr_tx(wr_tx),
        .wr_stat(wr_stat), .wr_vec(wr_vec), .wdata(bus_wdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_out_done(dev_out_done), .rx_q(rx_q), .tx_q(tx_q), .vec_q(vec_q),
        .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .rx_ie(rx_ie), .tx_ie(tx_ie),
        .tx_strobe(dev_out_valid)
    );

    byte_port_irq u_irq (
        .clk(clk), .rst_n(rst_n), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .iack_in(iack_in), .irq(irq_o),
        .claim(claim), .iack_out(iack_out)
    );

    // Status byte assembly
    always_comb begin
        stat_v              = '0;
        stat_v[STAT_RX_RDY] = rx_rdy;
        stat_v[STAT_TX_RDY] = tx_rdy;
        stat_v[STAT_RX_IE]  = rx_ie;
        stat_v[STAT_TX_IE]  = tx_ie;
    end

    // Read bus: claimed vector, decoded register read, else zero
    always_comb begin
        bus_rdata = '0;
        if (claim) begin
            bus_rdata = vec_q;
        end else if (hit && !bus_wr) begin
            case (which)
                SEL_RX:   bus_rdata = rx_q;
                SEL_TX:   bus_rdata = tx_q;
                SEL_STAT: bus_rdata = stat_v;
                default:  bus_rdata = vec_q;
            endcase
        end
    end

    assign dev_out_data = tx_q;
endmodule

// File: rtl/byte_port_ctrl_chk.sv
// Protocol checker for byte_port_ctrl, attached by bind below.
module byte_port_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              iack_in,
    input logic              iack_out,
    input logic              irq_o,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              dev_in_valid,
    input logic              dev_out_valid,
    input logic              wr_tx,
    input logic              rx_rdy,
    input logic              tx_rdy,
    input logic              rx_ie,
    input logic              tx_ie
);
    // R2
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_valid |=> rx_rdy);

    // R3
    tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> (dev_out_valid && !tx_rdy));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((rx_rdy && rx_ie) || (tx_rdy && tx_ie)));

    // R6
    claim_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_in && irq_o) |=> !irq_o);

    // R6
    claim_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_in && irq_o) |-> !iack_out);

    // R8
    pass_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_in && !irq_o) |-> iack_out);

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !iack_in) |-> (bus_rdata == '0));
endmodule

bind byte_port_ctrl byte_port_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .iack_in(iack_in),
    .iack_out(iack_out), .irq_o(irq_o), .bus_rdata(bus_rdata),
    .dev_in_valid(dev_in_valid), .dev_out_valid(dev_out_valid), .wr_tx(wr_tx),
    .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .rx_ie(rx_ie), .tx_ie(tx_ie)
);

// File: tb/byte_port_ctrl_bench.sv
`timescale 1ns/1ps
module byte_port_ctrl_bench;
    localparam logic [15:0] B = 16'h8000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 0, bus_wr = 0, iack_in = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, dev_in_data = '0;
    logic       dev_in_valid = 0, dev_out_done = 0;
    logic [7:0] bus_rdata, dev_out_data;
    logic       irq_o, iack_out, dev_out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    byte_port_ctrl u_byte_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .iack_in(iack_in), .iack_out(iack_out),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_done(dev_out_done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic push(logic [7:0] d);
        @(negedge clk);
        dev_in_valid = 1; dev_in_data = d;
        @(negedge clk);
        dev_in_valid = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(B + 4, v); chk("R1 status", v, 8'h02);
        rd(B + 6, v); chk("R1 vector", v, 8'h00);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_input;
        logic [7:0] v;
        push(8'h5A);
        rd(B + 4, v); chk("R2 rx flag set", v[0], 1);
        rd(B + 0, v); chk("R2 rx data", v, 8'h5A);
        rd(B + 4, v); chk("R2 rx flag clear", v[0], 0);
    endtask

    task automatic t_output;
        logic [7:0] v;
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = B + 2; bus_wdata = 8'hC3;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        chk("R3 strobe", dev_out_valid, 1);
        chk("R3 out data", dev_out_data, 8'hC3);
        @(negedge clk);
        chk("R3 strobe single", dev_out_valid, 0);
        rd(B + 4, v); chk("R3 tx busy", v[1], 0);
        @(negedge clk); dev_out_done = 1;
        @(negedge clk); dev_out_done = 0;
        rd(B + 4, v); chk("R3 tx ready again", v[1], 1);
    endtask

    task automatic t_enables;
        logic [7:0] v;
        wr(B + 4, 8'h0C);
        rd(B + 4, v); chk("R4 enables", v, 8'h0E);
        wr(B + 4, 8'h01);
        rd(B + 4, v); chk("R4 flag bits write-ignored", v, 8'h02);
    endtask

    task automatic t_irq_levels;
        logic [7:0] v;
        push(8'h11);
        @(negedge clk); chk("R5 no enable no irq", irq_o, 0);
        wr(B + 4, 8'h04);
        @(negedge clk); chk("R5 rx irq", irq_o, 1);
        rd(B + 0, v);
        @(negedge clk); chk("R5 irq drops", irq_o, 0);
        wr(B + 4, 8'h08);
        @(negedge clk); chk("R5 tx irq", irq_o, 1);
        wr(B + 4, 8'h00);
        @(negedge clk); chk("R5 tx irq off", irq_o, 0);
    endtask

    task automatic t_vector_claim;
        logic [7:0] v;
        wr(B + 6, 8'h40);
        rd(B + 6, v); chk("R9 vector", v, 8'h40);
        wr(B + 4, 8'h04);
        push(8'h22);
        @(negedge clk); chk("R6 irq before ack", irq_o, 1);
        iack_in = 1;
        #1 chk("R6 vector on bus", bus_rdata, 8'h40);
        chk("R6 no pass", iack_out, 0);
        @(negedge clk); iack_in = 0;
        chk("R6 irq low after ack", irq_o, 0);
        rd(B + 4, v); chk("R6 flag still set", v[0], 1);
        chk("R6 irq still low", irq_o, 0);
        rd(B + 0, v);
        @(negedge clk);
        push(8'h33);
        @(negedge clk); chk("R7 rearm", irq_o, 1);
        rd(B + 0, v);
        wr(B + 4, 8'h00);
    endtask

    task automatic t_pass;
        @(negedge clk);
        iack_in = 1;
        #1 chk("R8 pass on", iack_out, 1);
        chk("R8 bus zero", bus_rdata, 8'h00);
        @(negedge clk); iack_in = 0;
    endtask

    task automatic t_decode;
        logic [7:0] v;
        wr(B + 8, 8'h99);
        wr(B + 7, 8'h99);
        wr(16'h4006, 8'h99);
        rd(B + 6, v); chk("R10 vector untouched", v, 8'h40);
        rd(B + 10, v); chk("R10 outside reads zero", v, 8'h00);
        rd(B + 5, v); chk("R10 odd reads zero", v, 8'h00);
        wr(B + 12, 8'h0C);
        rd(B + 4, v); chk("R10 status untouched", v, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_input;
        t_output;
        t_enables;
        t_irq_levels;
        t_vector_claim;
        t_pass;
        t_decode;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule